// File: doc/BRIEF.md
# Segmented Hybrid Binary Adder

This block adds two unsigned 32-bit words and an incoming carry. It produces a 32-bit sum and an outgoing carry. The result is purely combinational and holds no state. In its default form the word is split into five segments along the bit range, and each segment uses its own carry technique. From least to most significant the segments are: a 4-bit ripple chain at [3:0], an 8-bit carry-select stage at [11:4], an 8-bit conditional-sum stage at [19:12], an 8-bit parallel-prefix tree of the up-sweep/down-sweep kind at [27:20], and a 4-bit lookahead group at [31:28]. The carry leaving each segment is the carry entering the next.

The `ARCH` parameter can also build the whole word from a single technique, so each technique can be compared with the hybrid in timing and area. All six variants compute the same function. Every segment's carry logic is written out gate by gate rather than left to an inferred `+`.

Top module: `hybrid_adder`

## Requirements
- R1: For every opa, opb and cin, {cout, sum} equals the 33-bit value opa + opb + cin.
- R2: A carry generated at the top bit of one segment reaches the next segment. Adding 1<<k to itself, for k = 3, 11, 19 and 27, gives sum 1<<(k+1) with cout 0.
- R3: A carry travels the full word. With opa = 0xFFFFFFFF, opb = 0 and cin = 1, the result is sum 0 and cout 1. With cin = 0, the sum is 0xFFFFFFFF and cout is 0. Complementary patterns such as 0xAAAAAAAA + 0x55555555 likewise ripple cin from bit 0 to cout.
- R4: In the carry-select segment, each 4-bit block computes two candidates, for carry-in 0 and for carry-in 1. The carry-in-1 candidate, carry included, is always the carry-in-0 candidate plus one. The block's incoming carry picks between them.
- R5: The conditional-sum segment merges groups of doubling width (1, 2, 4, 8). Its final candidate pair keeps the same plus-one relation, and the segment's carry-in picks the result.
- R6: When the prefix tree's down-sweep ends, every node's group reaches bit 0, so every group-propagate output is 0. The top group-generate equals the segment carry-out.
- R7: A generate in bit 31 alone drives cout. 0x80000000 + 0x80000000 gives sum 0 and cout 1.
- R8: The ARCH values 0 (hybrid), 1 (ripple), 2 (carry-select), 3 (conditional-sum), 4 (prefix) and 5 (lookahead) all give identical sum and cout for identical inputs.
- R9: Extreme inputs: 0 + 0 + 0 gives 0 with cout 0. 0xFFFFFFFF + 0xFFFFFFFF + 1 gives 0xFFFFFFFF with cout 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First addend |
| opb | input | WIDTH | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| cout | output | 1 | Carry out of the top bit |

## Verification
The checks are immediate assertions inside combinational processes. They assume every input is a known two-state value and that all three inputs change together, so each evaluation sees one consistent operand set. The assertions also assume the width parameters fit each technique: power-of-two widths for the conditional-sum and prefix segments, and multiples of the block size for the select and lookahead segments. The stimulus meets these assumptions. It drives all operands at once on the falling clock edge, never leaves them undriven, and uses only the default 32-bit layout.

// File: rtl/hyb_pkg.sv
package hyb_pkg;

  typedef enum logic [2:0] {
    ARCH_HYBRID    = 3'd0,
    ARCH_RIPPLE    = 3'd1,
    ARCH_CSEL      = 3'd2,
    ARCH_CSUM      = 3'd3,
    ARCH_PREFIX    = 3'd4,
    ARCH_LOOKAHEAD = 3'd5
  } arch_e;

  // segment widths from least to most significant (last one takes the rest)
  localparam int RIP_SEG_W  = 4;
  localparam int CSEL_SEG_W = 8;
  localparam int CSUM_SEG_W = 8;
  localparam int PFX_SEG_W  = 8;

  // block sizes inside the select and lookahead structures
  localparam int CSEL_BLK_W = 4;
  localparam int LA_GRP_W   = 4;

endpackage

// File: rtl/add_ripple.sv
module add_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  logic [W:0] c;

  assign c[0] = ci;

  for (genvar i = 0; i < W; i++) begin : bit_g
    assign s[i]   = a[i] ^ b[i] ^ c[i];
    assign c[i+1] = (a[i] & b[i]) | ((a[i] ^ b[i]) & c[i]);
  end

  assign co = c[W];

  always_comb begin
    // R1
    rip_sum_chk: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci}));
  end

endmodule

// File: rtl/add_csel.sv
module add_csel #(
  parameter int W   = 8,
  parameter int BLK = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  localparam int NB = W / BLK;

  logic [NB:0] bc;

  assign bc[0] = ci;

  for (genvar k = 0; k < NB; k++) begin : blk_g
    logic [BLK-1:0] s_lo, s_hi;
    logic           c_lo, c_hi;

    add_ripple #(.W(BLK)) u_zero (
      .a (a[k*BLK +: BLK]), .b (b[k*BLK +: BLK]), .ci (1'b0),
      .s (s_lo), .co (c_lo)
    );
    add_ripple #(.W(BLK)) u_one (
      .a (a[k*BLK +: BLK]), .b (b[k*BLK +: BLK]), .ci (1'b1),
      .s (s_hi), .co (c_hi)
    );

    assign s[k*BLK +: BLK] = bc[k] ? s_hi : s_lo;
    assign bc[k+1]         = bc[k] ? c_hi : c_lo;

    always_comb begin
      // R4
      csel_pair_chk: assert ({c_hi, s_hi} == ({c_lo, s_lo} + (BLK+1)'(1)));
    end
  end

  assign co = bc[NB];

endmodule

// File: rtl/add_csum.sv
module add_csum #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  localparam int LV = $clog2(W);

  for (genvar l = 0; l <= LV; l++) begin : lv
    logic [W-1:0]        gs0, gs1;   // candidate sums per bit
    logic [(W>>l)-1:0]   gc0, gc1;   // candidate carries per group

    if (l == 0) begin : base
      assign gs0 = a ^ b;
      assign gs1 = ~(a ^ b);
      assign gc0 = a & b;
      assign gc1 = a | b;
    end else begin : mrg
      localparam int HALF = 1 << (l - 1);
      for (genvar i = 0; i < W; i++) begin : sb
        if (((i / HALF) % 2) == 1) begin : hi
          assign gs0[i] = lv[l-1].gc0[(i/HALF)-1] ? lv[l-1].gs1[i] : lv[l-1].gs0[i];
          assign gs1[i] = lv[l-1].gc1[(i/HALF)-1] ? lv[l-1].gs1[i] : lv[l-1].gs0[i];
        end else begin : lo
          assign gs0[i] = lv[l-1].gs0[i];
          assign gs1[i] = lv[l-1].gs1[i];
        end
      end
      for (genvar j = 0; j < (W >> l); j++) begin : gc
        assign gc0[j] = lv[l-1].gc0[2*j] ? lv[l-1].gc1[2*j+1] : lv[l-1].gc0[2*j+1];
        assign gc1[j] = lv[l-1].gc1[2*j] ? lv[l-1].gc1[2*j+1] : lv[l-1].gc0[2*j+1];
      end
    end
  end

  logic [W-1:0] fin_s0, fin_s1;
  logic         fin_c0, fin_c1;

  assign fin_s0 = lv[LV].gs0;
  assign fin_s1 = lv[LV].gs1;
  assign fin_c0 = lv[LV].gc0[0];
  assign fin_c1 = lv[LV].gc1[0];

  assign s  = ci ? fin_s1 : fin_s0;
  assign co = ci ? fin_c1 : fin_c0;

  always_comb begin
    // R5
    csum_pair_chk: assert ({fin_c1, fin_s1} == ({fin_c0, fin_s0} + (W+1)'(1)));
  end

endmodule

// File: rtl/add_prefix.sv
module add_prefix #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  localparam int LV = $clog2(W);
  localparam int NS = 2 * LV - 1;

  logic [W-1:0] hp;

  assign hp = a ^ b;

  for (genvar st = 0; st <= NS; st++) begin : stg
    logic [W-1:0] g, p;

    if (st == 0) begin : base
      // carry-in folded into bit 0, so bit 0 never propagates
      assign g[0] = (a[0] & b[0]) | (hp[0] & ci);
      assign p[0] = 1'b0;
      if (W > 1) begin : rest
        assign g[W-1:1] = a[W-1:1] & b[W-1:1];
        assign p[W-1:1] = hp[W-1:1];
      end
    end else begin : nd
      localparam bit UP = (st <= LV);
      localparam int D  = UP ? (1 << (st - 1)) : (1 << (2 * LV - 1 - st));
      for (genvar i = 0; i < W; i++) begin : node
        localparam bit ACT = UP ? (((i + 1) % (2 * D)) == 0)
                                : ((((i + 1) % (2 * D)) == D) && ((i + 1) > D));
        if (ACT) begin : op
          assign g[i] = stg[st-1].g[i] | (stg[st-1].p[i] & stg[st-1].g[i-D]);
          assign p[i] = stg[st-1].p[i] & stg[st-1].p[i-D];
        end else begin : pass
          assign g[i] = stg[st-1].g[i];
          assign p[i] = stg[st-1].p[i];
        end
      end
    end
  end

  logic [W-1:0] gfin, pfin;

  assign gfin = stg[NS].g;
  assign pfin = stg[NS].p;

  assign s  = hp ^ {gfin[W-2:0], ci};
  assign co = gfin[W-1];

  always_comb begin
    // R6
    pfx_closed_chk: assert (pfin == '0);
    // R6
    pfx_carry_chk: assert (co == (({1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci}) >> W));
  end

endmodule

// File: rtl/add_lookahead.sv
module add_lookahead #(
  parameter int W   = 4,
  parameter int GRP = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  localparam int NG = W / GRP;

  logic [NG:0] gcar;

  assign gcar[0] = ci;

  for (genvar k = 0; k < NG; k++) begin : grp_g
    logic [GRP-1:0] gg, pp;
    logic [GRP:0]   cc;

    assign gg = a[k*GRP +: GRP] & b[k*GRP +: GRP];
    assign pp = a[k*GRP +: GRP] ^ b[k*GRP +: GRP];

    // every carry in the group formed as a flat sum of products
    always_comb begin
      logic acc, run;
      cc[0] = gcar[k];
      for (int n = 0; n < GRP; n++) begin
        acc = gg[n];
        run = pp[n];
        for (int m = n - 1; m >= 0; m--) begin
          acc = acc | (run & gg[m]);
          run = run & pp[m];
        end
        cc[n+1] = acc | (run & gcar[k]);
      end
    end

    assign s[k*GRP +: GRP] = pp ^ cc[GRP-1:0];
    assign gcar[k+1]       = cc[GRP];

    always_comb begin
      // R7
      la_grp_chk: assert ({cc[GRP], s[k*GRP +: GRP]} ==
                          ({1'b0, a[k*GRP +: GRP]} + {1'b0, b[k*GRP +: GRP]} + {{GRP{1'b0}}, gcar[k]}));
    end
  end

  assign co = gcar[NG];

endmodule

// File: rtl/hybrid_adder.sv
module hybrid_adder #(
  parameter hyb_pkg::arch_e ARCH  = hyb_pkg::ARCH_HYBRID,
  parameter int             WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  import hyb_pkg::*;

  localparam int O_CSEL = RIP_SEG_W;
  localparam int O_CSUM = O_CSEL + CSEL_SEG_W;
  localparam int O_PFX  = O_CSUM + CSUM_SEG_W;
  localparam int O_LA   = O_PFX + PFX_SEG_W;
  localparam int LA_W   = WIDTH - O_LA;

  if (ARCH == ARCH_HYBRID) begin : hyb
    logic [4:0] k;

    add_ripple #(.W(RIP_SEG_W)) u_rip (
      .a (opa[0 +: RIP_SEG_W]), .b (opb[0 +: RIP_SEG_W]), .ci (cin),
      .s (sum[0 +: RIP_SEG_W]), .co (k[0])
    );
    add_csel #(.W(CSEL_SEG_W), .BLK(CSEL_BLK_W)) u_csel (
      .a (opa[O_CSEL +: CSEL_SEG_W]), .b (opb[O_CSEL +: CSEL_SEG_W]), .ci (k[0]),
      .s (sum[O_CSEL +: CSEL_SEG_W]), .co (k[1])
    );
    add_csum #(.W(CSUM_SEG_W)) u_csum (
      .a (opa[O_CSUM +: CSUM_SEG_W]), .b (opb[O_CSUM +: CSUM_SEG_W]), .ci (k[1]),
      .s (sum[O_CSUM +: CSUM_SEG_W]), .co (k[2])
    );
    add_prefix #(.W(PFX_SEG_W)) u_pfx (
      .a (opa[O_PFX +: PFX_SEG_W]), .b (opb[O_PFX +: PFX_SEG_W]), .ci (k[2]),
      .s (sum[O_PFX +: PFX_SEG_W]), .co (k[3])
    );
    add_lookahead #(.W(LA_W), .GRP(LA_GRP_W)) u_la (
      .a (opa[O_LA +: LA_W]), .b (opb[O_LA +: LA_W]), .ci (k[3]),
      .s (sum[O_LA +: LA_W]), .co (k[4])
    );

    assign cout = k[4];
  end else if (ARCH == ARCH_RIPPLE) begin : rip
    add_ripple #(.W(WIDTH)) u_all (
      .a (opa), .b (opb), .ci (cin), .s (sum), .co (cout)
    );
  end else if (ARCH == ARCH_CSEL) begin : csel
    add_csel #(.W(WIDTH), .BLK(CSEL_BLK_W)) u_all (
      .a (opa), .b (opb), .ci (cin), .s (sum), .co (cout)
    );
  end else if (ARCH == ARCH_CSUM) begin : csum
    add_csum #(.W(WIDTH)) u_all (
      .a (opa), .b (opb), .ci (cin), .s (sum), .co (cout)
    );
  end else if (ARCH == ARCH_PREFIX) begin : pfx
    add_prefix #(.W(WIDTH)) u_all (
      .a (opa), .b (opb), .ci (cin), .s (sum), .co (cout)
    );
  end else begin : la
    add_lookahead #(.W(WIDTH), .GRP(LA_GRP_W)) u_all (
      .a (opa), .b (opb), .ci (cin), .s (sum), .co (cout)
    );
  end

  always_comb begin
    // R1
    add_result_chk: assert ({cout, sum} ==
                            ({1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin}));
  end

endmodule

// File: tb/sim_hybrid_adder.sv
module sim_hybrid_adder;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 32;
  localparam int N_RAND     = 3000;
  localparam int WD_LIMIT   = 20000;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] opa, opb;
  logic         cin;

  logic [W-1:0] s0, s1, s2, s3, s4, s5;
  logic         c0, c1, c2, c3, c4, c5;

  int unsigned n_chk;
  int unsigned n_err;
  int unsigned cyc;
  bit          done;

  hybrid_adder #(.ARCH(hyb_pkg::ARCH_HYBRID), .WIDTH(W)) u0 (
    .opa (opa), .opb (opb), .cin (cin), .sum (s0), .cout (c0));
  hybrid_adder #(.ARCH(hyb_pkg::ARCH_RIPPLE), .WIDTH(W)) u1 (
    .opa (opa), .opb (opb), .cin (cin), .sum (s1), .cout (c1));
  hybrid_adder #(.ARCH(hyb_pkg::ARCH_CSEL), .WIDTH(W)) u2 (
    .opa (opa), .opb (opb), .cin (cin), .sum (s2), .cout (c2));
  hybrid_adder #(.ARCH(hyb_pkg::ARCH_CSUM), .WIDTH(W)) u3 (
    .opa (opa), .opb (opb), .cin (cin), .sum (s3), .cout (c3));
  hybrid_adder #(.ARCH(hyb_pkg::ARCH_PREFIX), .WIDTH(W)) u4 (
    .opa (opa), .opb (opb), .cin (cin), .sum (s4), .cout (c4));
  hybrid_adder #(.ARCH(hyb_pkg::ARCH_LOOKAHEAD), .WIDTH(W)) u5 (
    .opa (opa), .opb (opb), .cin (cin), .sum (s5), .cout (c5));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic cmp(input string req, input string who, input logic [W:0] got,
                     input logic [W:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got cout=%0b sum=%08h expected cout=%0b sum=%08h",
               req, who, got[W], got[W-1:0], exp[W], exp[W-1:0]);
    end
  endtask

  // drive on the falling edge, sample one time unit later (no registers on the path)
  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c,
                       input string req);
    logic [W:0] e;
    @(negedge clk);
    opa = x;
    opb = y;
    cin = c;
    #1;
    e = ref_add(x, y, c);
    cmp(req, "hybrid", {c0, s0}, e);
    cmp("R8", "ripple", {c1, s1}, e);
    cmp("R8", "select", {c2, s2}, e);
    cmp("R8", "condsum", {c3, s3}, e);
    cmp("R8", "prefix", {c4, s4}, e);
    cmp("R8", "lookahead", {c5, s5}, e);
  endtask

  task automatic apply_exp(input logic [W-1:0] x, input logic [W-1:0] y, input logic c,
                           input logic [W:0] hand, input string req);
    apply(x, y, c, req);
    cmp(req, "hand-value", {c0, s0}, hand);
  endtask

  always @(posedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (cyc > WD_LIMIT) begin
        n_err++;
        n_chk++;
        done = 1'b1;
        $display("FAIL watchdog: got %0d cycles expected at most %0d", cyc, WD_LIMIT);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    cyc   = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    opa   = '0;
    opb   = '0;
    cin   = 1'b0;
    void'($urandom(32'h5EED_2024));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R9 extremes
    apply_exp(32'h0, 32'h0, 1'b0, 33'h0_0000_0000, "R9");
    apply_exp(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 33'h1_FFFF_FFFF, "R9");

    // R3 full-length propagation, with and without carry-in
    apply_exp(32'hFFFF_FFFF, 32'h0, 1'b1, 33'h1_0000_0000, "R3");
    apply_exp(32'hFFFF_FFFF, 32'h0, 1'b0, 33'h0_FFFF_FFFF, "R3");
    apply_exp(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 33'h1_0000_0000, "R3");
    apply_exp(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 33'h0_FFFF_FFFF, "R3");
    apply_exp(32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 33'h1_0000_0000, "R3");

    // R2 carry across each segment boundary
    for (int k = 3; k <= 27; k += 8) begin
      apply_exp(32'd1 << k, 32'd1 << k, 1'b0, 33'd1 << (k + 1), "R2");
    end

    // R4 carry-select segment: carry entering at bit 4 crossing both blocks
    apply_exp(32'h0000_0FF8, 32'h0000_0008, 1'b0, 33'h0_0000_1000, "R4");
    apply_exp(32'h0000_0FF0, 32'h0000_0000, 1'b1, 33'h0_0000_0FF1, "R4");
    // R5 conditional-sum segment: carry entering at bit 12 crossing all 8 bits
    apply_exp(32'h000F_F800, 32'h0000_0800, 1'b0, 33'h0_0010_0000, "R5");
    // R6 prefix segment: propagate run through bits 27:20
    apply_exp(32'h0FF8_0000, 32'h0008_0000, 1'b0, 33'h0_1000_0000, "R6");
    apply_exp(32'h0AB0_0000, 32'h0450_0000, 1'b0, 33'h0_0F00_0000, "R6");
    // R7 lookahead segment on top
    apply_exp(32'h8000_0000, 32'h8000_0000, 1'b0, 33'h1_0000_0000, "R7");
    apply_exp(32'h7000_0000, 32'h1000_0000, 1'b0, 33'h0_8000_0000, "R7");

    // R1 random, with a share of long propagate runs
    for (int n = 0; n < N_RAND; n++) begin
      logic [W-1:0] x, y;
      x = $urandom;
      y = $urandom;
      case ($urandom % 4)
        0: y = ~x;
        1: y = ~x ^ (32'd1 << ($urandom % 32));
        default: ;
      endcase
      apply(x, y, 1'($urandom), "R1");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule